// File: doc/BRIEF.md
# Weighted Hardware Thread Slot Scheduler

This block chooses, on every clock, which of eight hardware threads may issue into a shared single-issue pipeline. The choice is not round-robin. A 3-bit mode input selects a fixed pattern of unequal power-of-two bandwidth shares, and the pattern repeats over a 16-slot frame. Each thread therefore gets a guaranteed fraction of the clocks that is a multiple of 1/16, and no software scheduler is needed.

An 8-bit enable mask takes threads out of the schedule. A slot that belongs to a disabled thread stays idle and is never handed to another thread. Some modes serve fewer than eight threads, and some leave slots with no owner at all. The mode and the mask are sampled only when the frame wraps, so the pattern never changes inside a frame. The outputs are a registered one-hot grant, the matching thread index, and a valid flag.

Top module: `thread_slot_sched`

## Requirements
- R1: `grant_o` is one-hot or all zero in every cycle. `valid_o` is high exactly when `grant_o` is non-zero. When `valid_o` is high, `thread_o` is the index of the set grant bit; otherwise `thread_o` is 0.
- R2: With all threads enabled, one frame gives each thread this many slots, listed for threads 0..7:
  - mode 0: 8,2,1,1,1,1,1,1
  - mode 1: 4,4,2,2,1,1,1,1
  - mode 2: 2 each
  - mode 3: 8,2,2,2,0,0,0,0
  - mode 4: 4,4,4,2,2,0,0,0
  - mode 5: 1,4,4,4,1,1,1,0
  - mode 6: 1,8,2,1,1,1,1,1
  - mode 7: 2,8,2,2,2,0,0,0
- R3: A thread that holds c slots in a frame gets them exactly 16/c slots apart. In mode 0, thread 0 holds slot 0 and every even slot.
- R4: A slot owned by a thread whose enable bit is 0 gives no grant. The slots of enabled threads are the same as with all threads enabled.
- R5: Slots that the mode gives to no thread are idle. Mode 3 has 2 such slots per frame.
- R6: `mode_i` and `thr_en_i` are sampled only at the clock edge where the slot counter goes from 15 to 0. A change in the middle of a frame has no effect until the next frame.
- R7: While `rst` is high, all outputs are 0. Reset sets the slot counter to 0, the mode to 0 and the enable mask to 8'h01. The first frame after reset therefore grants thread 0 in the even slots and leaves the odd slots idle.
- R8: The output after the j-th rising edge following reset release shows slot (j-1) mod 16 of the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Share pattern select, sampled at frame wrap |
| thr_en_i | input | 8 | Per-thread enable mask, sampled at frame wrap |
| grant_o | output | 8 | One-hot issue grant for the current slot |
| thread_o | output | 3 | Index of the granted thread |
| valid_o | output | 1 | A thread holds the current slot |

## Verification
Two functions can act in the same cycle: the configuration latch at the frame wrap, and the grant of the last slot of the outgoing frame. The bench changes the mode and the mask in the middle of a running frame. It then checks that every remaining slot still follows the old pattern and that the next frame follows the new one. Each frame is judged by the slot count of each thread, the spacing between a thread's slots, and the number of idle slots. A reset asserted in the middle of a frame is checked the same way against the reset defaults.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int NTHR   = 8;
  localparam int TID_W  = $clog2(NTHR);
  localparam int SLOT_W = 4;
  localparam int FRAME  = 1 << SLOT_W;
  localparam int MODE_W = 3;
  localparam int NMODE  = 1 << MODE_W;
  localparam int EXP_W  = 4;

  typedef struct packed {
    logic             used;
    logic [TID_W-1:0] tid;
  } slot_ent_t;

  // Share exponent per thread (nibble t = thread t): share = 1/2^k, k=0 means no slots.
  function automatic logic [NTHR*EXP_W-1:0] share_row(input int m);
    case (m)
      0:       share_row = 32'h44444431;
      1:       share_row = 32'h44443322;
      2:       share_row = 32'h33333333;
      3:       share_row = 32'h00003331;
      4:       share_row = 32'h00033222;
      5:       share_row = 32'h04442224;
      6:       share_row = 32'h44444314;
      default: share_row = 32'h00033313;
    endcase
  endfunction

  function automatic int bit_rev(input int s);
    int r;
    r = 0;
    for (int i = 0; i < SLOT_W; i++)
      if (((s >> i) & 1) == 1) r = r | (1 << (SLOT_W - 1 - i));
    return r;
  endfunction

  // Larger shares take aligned blocks of the bit-reversed slot space first,
  // which spreads each thread's slots evenly across the frame.
  function automatic slot_ent_t owner_of(input int m, input int s);
    slot_ent_t e;
    logic [NTHR*EXP_W-1:0] row;
    int base;
    int r;
    int span;
    e    = '0;
    row  = share_row(m);
    base = 0;
    r    = bit_rev(s);
    for (int k = 1; k <= SLOT_W; k++) begin
      for (int t = 0; t < NTHR; t++) begin
        if (int'(row[t*EXP_W +: EXP_W]) == k) begin
          span = FRAME >> k;
          if (r >= base && r < base + span) begin
            e.used = 1'b1;
            e.tid  = TID_W'(t);
          end
          base = base + span;
        end
      end
    end
    return e;
  endfunction
endpackage

// File: rtl/tss_slot_counter.sv
module tss_slot_counter #(
  parameter int SLOT_W = tss_pkg::SLOT_W,
  parameter int MODE_W = tss_pkg::MODE_W,
  parameter int NTHR   = tss_pkg::NTHR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [NTHR-1:0]   en_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [NTHR-1:0]   en_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = {SLOT_W{1'b1}};
  localparam logic [NTHR-1:0]   EN_RST    = NTHR'(1);

  logic [SLOT_W-1:0] slot_q;
  logic [MODE_W-1:0] mode_q;
  logic [NTHR-1:0]   en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      mode_q <= '0;
      en_q   <= EN_RST;
    end else begin
      slot_q <= slot_q + 1'b1;
      if (slot_q == LAST_SLOT) begin
        mode_q <= mode_i;
        en_q   <= en_i;
      end
    end
  end

  assign slot_o = slot_q;
  assign mode_o = mode_q;
  assign en_o   = en_q;

  p_slot_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (slot_q == LAST_SLOT) |=> (slot_q == '0));
  p_slot_step_r8: assert property (@(posedge clk) disable iff (rst)
    (slot_q != LAST_SLOT) |=> (slot_q == $past(slot_q) + 1'b1));
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (slot_q != '0) |-> ($stable(mode_q) && $stable(en_q)));
endmodule

// File: rtl/tss_slot_table.sv
module tss_slot_table #(
  parameter int SLOT_W = tss_pkg::SLOT_W,
  parameter int MODE_W = tss_pkg::MODE_W
) (
  input  logic [MODE_W-1:0]     mode_i,
  input  logic [SLOT_W-1:0]     slot_i,
  output tss_pkg::slot_ent_t    ent_o
);
  localparam int DEPTH = (1 << MODE_W) * (1 << SLOT_W);

  tss_pkg::slot_ent_t rom [DEPTH];

  for (genvar m = 0; m < (1 << MODE_W); m++) begin : g_mode
    for (genvar s = 0; s < (1 << SLOT_W); s++) begin : g_slot
      assign rom[m * (1 << SLOT_W) + s] = tss_pkg::owner_of(m, s);
    end
  end

  assign ent_o = rom[{mode_i, slot_i}];
endmodule

// File: rtl/tss_grant_reg.sv
module tss_grant_reg #(
  parameter int NTHR  = tss_pkg::NTHR,
  parameter int TID_W = tss_pkg::TID_W
) (
  input  logic               clk,
  input  logic               rst,
  input  tss_pkg::slot_ent_t ent_i,
  input  logic [NTHR-1:0]    en_i,
  output logic [NTHR-1:0]    grant_o,
  output logic [TID_W-1:0]   tid_o,
  output logic               valid_o
);
  logic hit;

  always_comb hit = ent_i.used && en_i[ent_i.tid];

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= '0;
      tid_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= hit;
      tid_o   <= hit ? ent_i.tid : '0;
      grant_o <= hit ? (NTHR'(1) << ent_i.tid) : '0;
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));
  p_valid_r1: assert property (@(posedge clk) disable iff (rst)
    valid_o == (grant_o != '0));
  p_tid_r1: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> grant_o[tid_o]);
  p_no_steal_r4: assert property (@(posedge clk) disable iff (rst)
    (grant_o & ~$past(en_i)) == '0);
endmodule

// File: rtl/thread_slot_sched.sv
module thread_slot_sched #(
  parameter int NTHR   = tss_pkg::NTHR,
  parameter int TID_W  = tss_pkg::TID_W,
  parameter int SLOT_W = tss_pkg::SLOT_W,
  parameter int MODE_W = tss_pkg::MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [NTHR-1:0]   thr_en_i,
  output logic [NTHR-1:0]   grant_o,
  output logic [TID_W-1:0]  thread_o,
  output logic              valid_o
);
  logic [SLOT_W-1:0]  slot;
  logic [MODE_W-1:0]  mode;
  logic [NTHR-1:0]    en;
  tss_pkg::slot_ent_t ent;

  tss_slot_counter #(.SLOT_W(SLOT_W), .MODE_W(MODE_W), .NTHR(NTHR)) u_cnt (
    .clk(clk), .rst(rst), .mode_i(mode_i), .en_i(thr_en_i),
    .slot_o(slot), .mode_o(mode), .en_o(en)
  );

  tss_slot_table #(.SLOT_W(SLOT_W), .MODE_W(MODE_W)) u_tab (
    .mode_i(mode), .slot_i(slot), .ent_o(ent)
  );

  tss_grant_reg #(.NTHR(NTHR), .TID_W(TID_W)) u_grant (
    .clk(clk), .rst(rst), .ent_i(ent), .en_i(en),
    .grant_o(grant_o), .tid_o(thread_o), .valid_o(valid_o)
  );

  p_reset_quiet_r7: assert property (@(posedge clk)
    $past(rst) |-> (grant_o == '0 && !valid_o));
endmodule

// File: tb/sim_thread_slot_sched.sv
module sim_thread_slot_sched;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_i = 3'd2;
  logic [7:0] thr_en_i = 8'hFF;
  logic [7:0] grant_o;
  logic [2:0] thread_o;
  logic       valid_o;

  int total = 0;
  int bad   = 0;
  int ecnt  = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  thread_slot_sched u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i), .thr_en_i(thr_en_i),
    .grant_o(grant_o), .thread_o(thread_o), .valid_o(valid_o)
  );

  // Slot counts per frame, nibble t = thread t (R2)
  localparam logic [31:0] CNT_TAB [8] = '{
    32'h11111128, 32'h11112244, 32'h22222222, 32'h00002228,
    32'h00022444, 32'h01114441, 32'h11111281, 32'h00022282
  };

  // Stimulus vectors: {mode, enable}
  localparam logic [10:0] VEC [12] = '{
    {3'd0, 8'hFF}, {3'd1, 8'hFF}, {3'd2, 8'hFF}, {3'd3, 8'hFF},
    {3'd4, 8'hFF}, {3'd5, 8'hFF}, {3'd6, 8'hFF}, {3'd7, 8'hFF},
    {3'd0, 8'hA5}, {3'd6, 8'h0F}, {3'd3, 8'hF0}, {3'd1, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    ecnt++;
  endtask

  task automatic align();
    do tick(); while (ecnt % 16 != 0);
  endtask

  // Collect one frame (current ecnt % 16 == 0) and judge it against (m, en).
  // chg_at >= 0: after that slot, drive new inputs (must not affect this frame).
  task automatic collect(input int m, input logic [7:0] en, input int chg_at,
                         input logic [2:0] nm, input logic [7:0] nen);
    int cnt [8];
    int first [8];
    int idle;
    int exp_sum;
    int r1_bad;
    int r3_bad;
    int r4_bad;
    idle = 0; r1_bad = 0; r3_bad = 0; r4_bad = 0; exp_sum = 0;
    for (int t = 0; t < 8; t++) begin cnt[t] = 0; first[t] = -1; end
    for (int s = 0; s < 16; s++) begin
      int t;
      int c;
      tick();
      if ($countones(grant_o) > 1 || valid_o != (grant_o != 0) ||
          (valid_o && grant_o != (8'd1 << thread_o)) || (!valid_o && thread_o != 0))
        r1_bad++;
      if (valid_o) begin
        t = int'(thread_o);
        if (!en[t]) r4_bad++;
        cnt[t]++;
        c = int'(CNT_TAB[m][4*t +: 4]);
        if (first[t] < 0) first[t] = s;
        else if (c == 0 || ((s - first[t]) % (16 / c)) != 0) r3_bad++;
      end else idle++;
      if (s == chg_at) begin mode_i = nm; thr_en_i = nen; end
    end
    chk(r1_bad == 0, "R1 grant/valid/thread consistency", r1_bad, 0);
    for (int t = 0; t < 8; t++) begin
      int e;
      e = en[t] ? int'(CNT_TAB[m][4*t +: 4]) : 0;
      exp_sum += e;
      chk(cnt[t] == e, en[t] ? "R2 slot count" : "R4 disabled thread count", cnt[t], e);
    end
    chk(r3_bad == 0, "R3 even spacing", r3_bad, 0);
    chk(r4_bad == 0, "R4 grant to disabled thread", r4_bad, 0);
    chk(idle == 16 - exp_sum, "R5 idle slot count", idle, 16 - exp_sum);
    if (m == 0 && en[0]) chk(first[0] == 0, "R3/R8 thread 0 holds slot 0", first[0], 0);
  endtask

  initial begin
    // R7: outputs quiet in reset
    repeat (3) @(negedge clk);
    chk(grant_o == 0 && !valid_o && thread_o == 0, "R7 outputs zero in reset", int'(grant_o), 0);
    rst = 1'b0;
    ecnt = 0;
    // R6/R7: first frame uses mode 0, enable 8'h01 although inputs say mode 2, all on
    collect(0, 8'h01, -1, 3'd0, 8'h00);

    // Vector table
    for (int v = 0; v < 12; v++) begin
      mode_i = VEC[v][10:8];
      thr_en_i = VEC[v][7:0];
      align();
      collect(int'(VEC[v][10:8]), VEC[v][7:0], -1, 3'd0, 8'h00);
    end

    // R6: mid-frame change does not disturb the running frame
    mode_i = 3'd2; thr_en_i = 8'hFF;
    align();
    collect(2, 8'hFF, 5, 3'd3, 8'h01);
    collect(3, 8'h01, -1, 3'd0, 8'h00);
    // R6: change on the last slot of a frame still lands at the wrap
    mode_i = 3'd7; thr_en_i = 8'hFF;
    align();
    collect(7, 8'hFF, 14, 3'd5, 8'hFE);
    collect(5, 8'hFE, -1, 3'd0, 8'h00);

    // R7: reset in the middle of a frame restores defaults
    mode_i = 3'd5; thr_en_i = 8'hFF;
    repeat (5) tick();
    rst = 1'b1;
    tick(); tick();
    chk(grant_o == 0 && !valid_o, "R7 outputs zero after mid-frame reset", int'(grant_o), 0);
    rst = 1'b0;
    ecnt = 0;
    collect(0, 8'h01, -1, 3'd0, 8'h00);
    collect(5, 8'hFF, -1, 3'd0, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule